// File: doc/BRIEF.md
# Programmable countdown interrupt timer

This block counts down a loaded value at a rate set by a power-of-two prescaler on the bus clock. When the count reaches zero it raises a one-cycle request that carries an interrupt vector and a delivery-mode code. These go to a priority core, which is outside this block. Software reaches four registers through a single-cycle write port and a combinational read port. The registers are the timer's interrupt entry, the initial count, the live current count and the divide configuration.

Two count modes are offered. A one-shot count stops at zero and stays there. A periodic count shows zero for one prescaled tick and then reloads from the initial count. Writing the initial count restarts both the count and the prescaler. An initial count of zero leaves the timer idle.

Top module: `tmr_countdown`

## Requirements
- R1: A write to register address 3 (divide configuration) stores only data bits 0, 1 and 3. Reading address 3 returns the stored value with every other bit at zero.
- R2: The divide index is {bit 3, bit 1, bit 0} of the divide configuration. The shift is (index + 1) modulo 8, so code 4'b1011 divides by one. The count decrements once every 2^shift clock cycles. The first decrement comes 2^shift cycles after the edge that wrote the initial count.
- R3: A write to address 1 (initial count) loads the count with the written value at that clock edge and restarts the prescaler. Reading address 1 returns the stored initial count.
- R4: In one-shot mode (entry bit 17 = 0) the count decrements once per prescaled tick down to 0 and then holds at 0.
- R5: In periodic mode (entry bit 17 = 1) the count reads 0 for one prescaled tick and then reloads from the initial count. Each period is therefore (initial + 1) ticks long.
- R6: Writes to address 2 (current count) have no effect. Reading address 2 returns the live count.
- R7: In the cycle after the count steps from 1 to 0, irq_req is high for exactly one cycle. In that cycle irq_vector carries entry bits 7:0 and irq_mode carries entry bits 10:8. The request is suppressed if mask bit 16 of the entry was set at the step.
- R8: An initial count of 0 in either mode never raises irq_req.
- R9: A write to the initial count in the same cycle as the tick that would reach zero takes precedence. The count reloads and no request is raised.
- R10: The entry at address 0 stores vector bits 7:0, mode bits 10:8, mask bit 16 and periodic bit 17; other bits read 0. After reset, the entry reads 32'h0001_0000 (masked) and every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 entry, 1 initial count, 2 current count, 3 divide configuration |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| irq_req | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector sent with the request |
| irq_mode | output | 3 | Delivery-mode code sent with the request |

## Verification
Two events can land on the same clock edge: the tick that takes the count from 1 to 0, and a software write of the initial count. The bench provokes this by rewriting the initial count with 1 on every cycle while dividing by one. Each rewrite then falls on the cycle whose tick would expire the count. The cycle-accurate reference model gives the load precedence, so the design must show no request throughout the rewrites. It must then raise exactly one request once the rewrites stop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned VEC_W      = 8;
   localparam int unsigned MODE_W     = 3;
   localparam int unsigned B_MODE_LO  = 8;
   localparam int unsigned B_MASK     = 16;
   localparam int unsigned B_PERIODIC = 17;
   localparam int unsigned ENTRY_MSB  = B_PERIODIC;

   typedef enum logic [1:0] {
      RA_ENTRY = 2'd0,
      RA_INIT  = 2'd1,
      RA_COUNT = 2'd2,
      RA_DIV   = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic              periodic;
      logic              mask;
      logic [MODE_W-1:0] mode;
      logic [VEC_W-1:0]  vec;
   } entry_t;

   // divide index = {cfg[3], cfg[1:0]}; shift wraps modulo 8
   function automatic logic [2:0] div_shift(input logic [3:0] cfg);
      logic [2:0] idx;
      idx = {cfg[3], cfg[1:0]};
      return idx + 3'd1;
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] shift,
   output logic       tick
);

   localparam int MAX_SHIFT = 7;

   generate
      if (PRE_W < MAX_SHIFT) begin : g_bad_width
         $error("tmr_prescaler: PRE_W must cover a shift of 7");
      end
   endgenerate

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] lim_mask;

   // low 'shift' bits of the mask are set
   generate
      for (genvar i = 0; i < PRE_W; i++) begin : g_mask
         if (i < MAX_SHIFT) begin : g_live
            assign lim_mask[i] = (3'(i) < shift);
         end else begin : g_zero
            assign lim_mask[i] = 1'b0;
         end
      end
   endgenerate

   assign tick = &(pcnt | ~lim_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (restart) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr_counter: CNT_W too small");
      end
   endgenerate

   // a load on the same edge wins over the step to zero
   assign expire = tick && !load && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         if (count == '0) begin
            if (periodic) begin
               count <= reload_val;
            end
         end else begin
            count <= count - ONE;
         end
      end
   end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] live_count,
   output entry_t            entry,
   output logic [DATA_W-1:0] init_val,
   output logic [3:0]        div_cfg,
   output logic              init_wr,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (DATA_W <= ENTRY_MSB) begin : g_bad_width
         $error("tmr_regs: DATA_W must hold the entry fields");
      end
   endgenerate

   reg_addr_e sel;
   assign sel     = reg_addr_e'(addr);
   assign init_wr = we && (sel == RA_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry    <= '{periodic: 1'b0, mask: 1'b1, mode: '0, vec: '0};
         init_val <= '0;
         div_cfg  <= '0;
      end else if (we) begin
         case (sel)
            RA_ENTRY: begin
               entry.vec      <= wdata[VEC_W-1:0];
               entry.mode     <= wdata[B_MODE_LO +: MODE_W];
               entry.mask     <= wdata[B_MASK];
               entry.periodic <= wdata[B_PERIODIC];
            end
            RA_INIT: init_val <= wdata;
            RA_DIV:  div_cfg  <= {wdata[3], 1'b0, wdata[1:0]};
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         RA_ENTRY: begin
            rdata[VEC_W-1:0]          = entry.vec;
            rdata[B_MODE_LO +: MODE_W] = entry.mode;
            rdata[B_MASK]             = entry.mask;
            rdata[B_PERIODIC]         = entry.periodic;
         end
         RA_INIT:  rdata = init_val;
         RA_COUNT: rdata = live_count;
         RA_DIV:   rdata[3:0] = div_cfg;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PRE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector,
   output logic [MODE_W-1:0] irq_mode
);

   entry_t           entry_q;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cur_count;
   logic [3:0]       div_cfg_q;
   logic [2:0]       shift;
   logic             init_wr;
   logic             tick;
   logic             expire;

   assign shift = div_shift(div_cfg_q);

   tmr_regs #(.DATA_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .live_count (cur_count),
      .entry      (entry_q),
      .init_val   (init_q),
      .div_cfg    (div_cfg_q),
      .init_wr    (init_wr),
      .rdata      (reg_rdata)
   );

   tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (init_wr),
      .shift   (shift),
      .tick    (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (init_wr),
      .load_val   (reg_wdata),
      .reload_val (init_q),
      .tick       (tick),
      .periodic   (entry_q.periodic),
      .count      (cur_count),
      .expire     (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req    <= 1'b0;
         irq_vector <= '0;
         irq_mode   <= '0;
      end else begin
         irq_req <= expire && !entry_q.mask;
         if (expire && !entry_q.mask) begin
            irq_vector <= entry_q.vec;
            irq_mode   <= entry_q.mode;
         end
      end
   end

endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [1:0]       reg_addr,
   input logic [CNT_W-1:0] reg_wdata,
   input logic             irq_req,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] init_val,
   input logic [3:0]       div_cfg,
   input logic             tick,
   input logic             mask,
   input logic             periodic
);

   logic init_wr;
   assign init_wr = reg_we && (reg_addr == 2'd1);

   p_div_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && reg_addr == 2'd3) |-> div_cfg == ($past(reg_wdata[3:0]) & 4'hB));

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_wr) |-> count == $past(reg_wdata));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!periodic && count == '0 && !init_wr) |=> count == '0);

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (periodic && count == '0 && tick && !init_wr) |=> count == $past(init_val));

   p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd2 && !tick) |=> $stable(count));

   p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   p_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> count == '0);

   p_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !$past(mask));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (init_val == '0 && count == '0) |=> !irq_req);

   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_wr) |-> !irq_req);

endmodule

bind tmr_countdown tmr_countdown_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_req   (irq_req),
   .count     (cur_count),
   .init_val  (init_q),
   .div_cfg   (div_cfg_q),
   .tick      (tick),
   .mask      (entry_q.mask),
   .periodic  (entry_q.periodic)
);

// File: tb/tb_tmr_countdown.sv
`timescale 1ns/1ps
module tb_tmr_countdown;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_mode;

   always #4 clk = ~clk;

   tmr_countdown dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .irq_vector(irq_vector), .irq_mode(irq_mode)
   );

   // reference model state
   logic [31:0] m_entry, m_init, m_cnt, m_div;
   int          m_pc;
   bit          m_req;
   logic [7:0]  m_vec;
   logic [2:0]  m_mode;

   int    vectors = 0;
   int    miscompares = 0;
   int    pulses = 0;
   string phase = "R10";
   bit    done = 1'b0;

   always @(posedge clk) begin : model
      int       sh, dv;
      bit       tk, hit;
      logic [31:0] e_old;
      if (!rst_n) begin
         m_entry = 32'h0001_0000; m_init = '0; m_cnt = '0; m_div = '0;
         m_pc = 0; m_req = 0; m_vec = '0; m_mode = '0;
      end else begin
         e_old = m_entry;
         sh  = (int'({m_div[3], m_div[1:0]}) + 1) % 8;
         dv  = 1 << sh;
         tk  = (m_pc % dv) == dv - 1;
         hit = 0;
         if (reg_we && reg_addr == 2'd1) begin
            m_cnt = reg_wdata; m_init = reg_wdata; m_pc = 0;
         end else begin
            m_pc = (m_pc + 1) % 128;
            if (tk) begin
               if (m_cnt == 0) begin
                  if (e_old[17]) m_cnt = m_init;
               end else begin
                  if (m_cnt == 1) hit = 1;
                  m_cnt = m_cnt - 1;
               end
            end
         end
         m_req = hit && !e_old[16];
         if (m_req) begin
            m_vec = e_old[7:0]; m_mode = e_old[10:8];
         end
         if (reg_we && reg_addr == 2'd0) m_entry = reg_wdata & 32'h0003_07FF;
         if (reg_we && reg_addr == 2'd3) m_div = reg_wdata & 32'h0000_000B;
      end
   end

   function automatic logic [31:0] model_read(input logic [1:0] a);
      case (a)
         2'd0: return m_entry;
         2'd1: return m_init;
         2'd2: return m_cnt;
         default: return m_div;
      endcase
   endfunction

   function automatic string field_tag(input logic [1:0] a);
      case (a)
         2'd0: return "R10";
         2'd1: return "R3";
         2'd2: return "R6";
         default: return "R1";
      endcase
   endfunction

   task automatic compare();
      logic [31:0] exp_rd;
      exp_rd = model_read(reg_addr);
      vectors++;
      if (reg_rdata !== exp_rd) begin
         miscompares++;
         $display("FAIL %s/%s rdata addr %0d: got %h expected %h",
                  phase, field_tag(reg_addr), reg_addr, reg_rdata, exp_rd);
      end
      if (irq_req !== m_req) begin
         miscompares++;
         $display("FAIL %s/R7 irq_req: got %b expected %b", phase, irq_req, m_req);
      end else if (m_req && (irq_vector !== m_vec || irq_mode !== m_mode)) begin
         miscompares++;
         $display("FAIL %s/R7 vector/mode: got %h/%0d expected %h/%0d",
                  phase, irq_vector, irq_mode, m_vec, m_mode);
      end
      if (irq_req === 1'b1) pulses++;
   endtask

   task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      compare();
      reg_we = we; reg_addr = a; reg_wdata = d;
   endtask

   task automatic idle(input int n, input logic [1:0] a);
      for (int i = 0; i < n; i++) step(1'b0, a, '0);
   endtask

   task automatic expect_pulses(input int got, input int exp, input string tag);
      vectors++;
      if (got != exp) begin
         miscompares++;
         $display("FAIL %s pulse count: got %0d expected %0d", tag, got, exp);
      end
   endtask

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state of every register
      phase = "R10";
      for (int a = 0; a < 4; a++) step(1'b0, 2'(a), '0);
      step(1'b1, 2'd0, 32'hFFFF_FFFF);
      step(1'b0, 2'd0, '0);

      // R1: divide configuration keeps bits 0,1,3
      phase = "R1";
      step(1'b1, 2'd3, 32'hFFFF_FFFF);
      step(1'b0, 2'd3, '0);
      step(1'b1, 2'd3, 32'h0000_0004);
      step(1'b0, 2'd3, '0);

      // R4: one-shot, divide by one
      phase = "R4";
      step(1'b1, 2'd0, 32'h0000_0341);
      step(1'b1, 2'd3, 32'h0000_000B);
      p0 = pulses;
      step(1'b1, 2'd1, 32'd5);
      idle(12, 2'd2);
      expect_pulses(pulses - p0, 1, "R4");

      // R2: each divide code
      phase = "R2";
      foreach (dcodes[k]) begin
         step(1'b1, 2'd3, dcodes[k]);
         step(1'b1, 2'd1, 32'd3);
         idle((1 << ((int'({dcodes[k][3], dcodes[k][1:0]}) + 1) % 8)) * 4 + 4, 2'd2);
      end

      // R5: periodic reload
      phase = "R5";
      step(1'b1, 2'd0, 32'h0002_0342);
      step(1'b1, 2'd3, 32'h0000_000B);
      step(1'b1, 2'd1, 32'd3);
      p0 = pulses;
      idle(20, 2'd2);
      expect_pulses(pulses - p0, 5, "R5");
      step(1'b1, 2'd3, 32'h0000_0000);
      step(1'b1, 2'd1, 32'd2);
      idle(30, 2'd2);

      // R6: writes to current count are ignored
      phase = "R6";
      step(1'b1, 2'd3, 32'h0000_000B);
      step(1'b1, 2'd1, 32'd7);
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 2'd2, 32'h1234_5678);
         step(1'b0, 2'd2, '0);
      end

      // R7: masked entry raises nothing
      phase = "R7";
      step(1'b1, 2'd0, 32'h0003_0155);
      step(1'b1, 2'd1, 32'd2);
      p0 = pulses;
      idle(20, 2'd2);
      expect_pulses(pulses - p0, 0, "R7");

      // R8: zero initial count, both modes
      phase = "R8";
      step(1'b1, 2'd0, 32'h0000_0341);
      step(1'b1, 2'd1, 32'd0);
      p0 = pulses;
      idle(10, 2'd2);
      step(1'b1, 2'd0, 32'h0002_0341);
      step(1'b1, 2'd1, 32'd0);
      idle(10, 2'd2);
      expect_pulses(pulses - p0, 0, "R8");

      // R9: initial-count write on the expiring tick
      phase = "R9";
      step(1'b1, 2'd0, 32'h0000_0566);
      step(1'b1, 2'd1, 32'd0);
      p0 = pulses;
      for (int i = 0; i < 6; i++) step(1'b1, 2'd1, 32'd1);
      step(1'b0, 2'd2, '0);
      expect_pulses(pulses - p0, 0, "R9");
      idle(5, 2'd2);
      expect_pulses(pulses - p0, 1, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   logic [31:0] dcodes [7] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA};

endmodule